// File: doc/BRIEF.md
# Bit-band alias access translator

This unit sits on the bus path between a single processor core and the memory system. Two address windows are treated as alias regions. Each 32-bit word inside an alias window stands for one bit of one byte in a matching real region. An aliased access is turned into a single-bit operation on that byte. All other traffic passes through without change.

An aliased read turns into one byte-wide downstream read, and the selected bit comes back zero-extended. An aliased write turns into a locked pair of downstream accesses: a byte read, then a byte write that changes only the addressed bit. The upstream side stays stalled until the write has been accepted. Accesses tagged as coming from any other initiator are never translated.

The upstream and downstream interfaces both use request/ready. The initiator holds its request stable until ready is seen high. A transfer completes in the cycle where both request and ready are high, and read data is valid in that same cycle. Alias addresses must be word aligned.

Top module: `bitband_xlate`

## Requirements
- R1: An address in 0x2200_0000..0x227F_FFFF is translated to the byte at 0x2000_0000 + (offset >> 5), where offset is the address minus 0x2200_0000. The bit index is (offset >> 2) & 7. For example, 0x2200_6008 targets bit 2 of the byte at 0x2000_0300.
- R2: An address in 0x4200_0000..0x42FF_FFFF is translated the same way onto the region starting at 0x4000_0000. The last alias word, 0x42FF_FFFC, targets bit 7 of byte 0x4007_FFFF.
- R3: An aliased read issues exactly one downstream read of the target byte address. The strobe has the single bit 1 << addr[1:0] set (little-endian: lane k is data bits 8k+7..8k). It returns 0x0000_0001 or 0x0000_0000 according to the targeted bit.
- R4: An aliased write issues a downstream byte read of the target, then a byte write to the same address with the same one-hot strobe. The written byte differs from the byte read only in the targeted bit. It is replicated on all four lanes.
- R5: Only bit 0 of the upstream write data gives the new bit value. All other data bits and the upstream strobe are ignored for aliased writes.
- R6: For an aliased write, upstream ready stays low until the downstream write is accepted. With w wait states per downstream access, the access takes 2(w+1) cycles. An aliased read takes w+1 cycles.
- R7: An address outside both alias windows (including 0x2280_0000 and 0x41FF_FFFC) passes through unchanged: request, direction, address, data, strobe and ready. Lock stays low.
- R8: When up_core is 0, every access passes through unchanged, even inside an alias window.
- R9: After reset, with no upstream request, no downstream request is issued and lock is low.
- R10: dn_lock is high for both accesses of an aliased write, and the write follows its read in the very next cycle. Aliased reads and pass-through accesses never assert it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req | input | 1 | Upstream request |
| up_write | input | 1 | Upstream direction, 1 = write |
| up_core | input | 1 | 1 when the request comes from the owning core |
| up_addr | input | 32 | Upstream byte address |
| up_wdata | input | 32 | Upstream write data |
| up_strb | input | 4 | Upstream byte strobes |
| up_ready | output | 1 | Upstream transfer completes this cycle |
| up_rdata | output | 32 | Upstream read data |
| dn_req | output | 1 | Downstream request |
| dn_write | output | 1 | Downstream direction, 1 = write |
| dn_lock | output | 1 | Downstream access belongs to an indivisible pair |
| dn_addr | output | 32 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data |
| dn_strb | output | 4 | Downstream byte strobes |
| dn_ready | input | 1 | Downstream transfer completes this cycle |
| dn_rdata | input | 32 | Downstream read data |

## Verification
The bound checker watches several rules on every cycle. Aliased reads return only bit 0. A locked read is always followed at once by a locked write. Locked accesses carry a one-hot strobe. Upstream completion of an aliased write coincides with the downstream write. Traffic outside the windows, or from other initiators, keeps its address and never locks. Only the bench scenarios can show the values themselves: the address arithmetic at the window edges, which bit is changed in memory, that data bits above bit 0 are ignored, and the cycle counts under downstream wait states.

// File: rtl/bb_pkg.sv
// Shared types for the bit-band alias translator.
// Assumes 32-bit data words with byte lanes in little-endian order.
package bb_pkg;

    // Controller state: idle/first phase, or second (write) phase of the RMW
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } rmw_state_e;

    // Result of translating one address
    typedef struct packed {
        logic        hit;
        logic [31:0] byte_addr;
        logic [2:0]  bit_idx;
    } bb_target_t;

endpackage

// File: rtl/bb_window_decode.sv
// Window decoder: checks the address against each alias window and computes
// the target byte address and bit index inside the matching real region.
// Assumes window bases are aligned to their span and the windows do not overlap.
module bb_window_decode #(
    parameter int                        ADDR_W      = 32,
    parameter int                        NUM_WIN     = 2,
    parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN*ADDR_W-1:0] REAL_BASES  = {32'h4000_0000, 32'h2000_0000},
    parameter logic [NUM_WIN*8-1:0]      SPAN_LOG2S  = {8'd24, 8'd23}
) (
    input  logic [ADDR_W-1:0] addr,
    output bb_pkg::bb_target_t target
);
    localparam int WORD_SHIFT = 5;   // 8 bits x 4 bytes of alias per real byte

    logic [NUM_WIN-1:0]      win_hit;
    logic [ADDR_W-1:0]       win_addr [NUM_WIN];
    logic [2:0]              win_bit  [NUM_WIN];

    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
        localparam logic [ADDR_W-1:0] AB   = ALIAS_BASES[gi*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] RB   = REAL_BASES[gi*ADDR_W +: ADDR_W];
        localparam int                SL   = int'(SPAN_LOG2S[gi*8 +: 8]);
        localparam logic [ADDR_W-1:0] MASK = (ADDR_W'(1) << SL) - ADDR_W'(1);

        logic [ADDR_W-1:0] offset;

        // Per-window match and arithmetic
        always_comb begin
            offset       = addr & MASK;
            win_hit[gi]  = (addr & ~MASK) == AB;
            win_addr[gi] = RB + (offset >> WORD_SHIFT);
            win_bit[gi]  = offset[4:2];
        end
    end

    // Select the translation of the window that matched
    always_comb begin
        target = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (win_hit[i]) begin
                target.hit       = 1'b1;
                target.byte_addr = win_addr[i];
                target.bit_idx   = win_bit[i];
            end
        end
    end

endmodule

// File: rtl/bb_lane_unit.sv
// Byte-lane helper: pulls the addressed bit out of a read word and builds the
// modified byte, replicated on every lane, with a one-hot strobe.
// Assumes DATA_W is a multiple of 8 and lane 0 holds the lowest byte.
module bb_lane_unit #(
    parameter int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [LANE_W-1:0] lane,
    input  logic [2:0]        bit_idx,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              new_bit,
    output logic              rd_bit,
    output logic [DATA_W-1:0] wr_word,
    output logic [LANES-1:0]  strb
);
    logic [7:0] old_byte;
    logic [7:0] new_byte;

    // Extract, modify and replicate the addressed byte
    always_comb begin
        old_byte          = rd_word[8*lane +: 8];
        rd_bit            = old_byte[bit_idx];
        new_byte          = old_byte;
        new_byte[bit_idx] = new_bit;
        wr_word           = {LANES{new_byte}};
        strb              = LANES'(1) << lane;
    end

endmodule

// File: rtl/bb_rmw_ctrl.sv
// Read-modify-write sequencer: when the locked read of an aliased write
// completes, it captures the merged write and drives the second phase until
// the downstream write is accepted.
// Assumes upstream holds its request stable while stalled.
module bb_rmw_ctrl #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dn_ready,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic [DATA_W-1:0] nxt_word,
    input  logic [LANES-1:0]  nxt_strb,
    output logic              in_write,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_word,
    output logic [LANES-1:0]  hold_strb
);
    bb_pkg::rmw_state_e state;

    // State advance: read accepted -> write phase, write accepted -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= bb_pkg::ST_IDLE;
        end else begin
            case (state)
                bb_pkg::ST_IDLE:  if (start && dn_ready) state <= bb_pkg::ST_WRITE;
                bb_pkg::ST_WRITE: if (dn_ready)          state <= bb_pkg::ST_IDLE;
                default:                                 state <= bb_pkg::ST_IDLE;
            endcase
        end
    end

    // Capture the write phase contents when the read completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr <= '0;
            hold_word <= '0;
            hold_strb <= '0;
        end else if (state == bb_pkg::ST_IDLE && start && dn_ready) begin
            hold_addr <= nxt_addr;
            hold_word <= nxt_word;
            hold_strb <= nxt_strb;
        end
    end

    assign in_write = (state == bb_pkg::ST_WRITE);

endmodule

// File: rtl/bitband_xlate.sv
// Bit-band alias translator top. Aliased reads become one byte read returning
// the bit zero-extended; aliased writes become a locked byte read then byte
// write. Everything else, and anything not from the owning core, passes through.
// Assumes word-aligned alias accesses and a stable request while ready is low.
module bitband_xlate #(
    parameter int                        ADDR_W      = 32,
    parameter int                        DATA_W      = 32,
    parameter int                        NUM_WIN     = 2,
    parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN*ADDR_W-1:0] REAL_BASES  = {32'h4000_0000, 32'h2000_0000},
    parameter logic [NUM_WIN*8-1:0]      SPAN_LOG2S  = {8'd24, 8'd23},
    localparam int                       LANES       = DATA_W / 8,
    localparam int                       LANE_W      = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  logic              up_write,
    input  logic              up_core,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [DATA_W-1:0] up_wdata,
    input  logic [LANES-1:0]  up_strb,
    output logic              up_ready,
    output logic [DATA_W-1:0] up_rdata,
    output logic              dn_req,
    output logic              dn_write,
    output logic              dn_lock,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    output logic [LANES-1:0]  dn_strb,
    input  logic              dn_ready,
    input  logic [DATA_W-1:0] dn_rdata
);
    bb_pkg::bb_target_t tgt;
    logic               alias_hit;
    logic               rd_bit;
    logic [DATA_W-1:0]  merged_word;
    logic [LANES-1:0]   lane_strb;
    logic               in_write;
    logic               rmw_start;
    logic [ADDR_W-1:0]  hold_addr;
    logic [DATA_W-1:0]  hold_word;
    logic [LANES-1:0]   hold_strb;

    bb_window_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_WIN     (NUM_WIN),
        .ALIAS_BASES (ALIAS_BASES),
        .REAL_BASES  (REAL_BASES),
        .SPAN_LOG2S  (SPAN_LOG2S)
    ) u_decode (
        .addr   (up_addr),
        .target (tgt)
    );

    bb_lane_unit #(
        .DATA_W (DATA_W)
    ) u_lane (
        .lane    (tgt.byte_addr[LANE_W-1:0]),
        .bit_idx (tgt.bit_idx),
        .rd_word (dn_rdata),
        .new_bit (up_wdata[0]),
        .rd_bit  (rd_bit),
        .wr_word (merged_word),
        .strb    (lane_strb)
    );

    bb_rmw_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rmw_start),
        .dn_ready  (dn_ready),
        .nxt_addr  (tgt.byte_addr),
        .nxt_word  (merged_word),
        .nxt_strb  (lane_strb),
        .in_write  (in_write),
        .hold_addr (hold_addr),
        .hold_word (hold_word),
        .hold_strb (hold_strb)
    );

    // Translation only for the owning core
    assign alias_hit = tgt.hit && up_core;
    assign rmw_start = up_req && up_write && alias_hit && !in_write;

    // Route the request: RMW write phase, aliased first phase, or pass-through
    always_comb begin
        dn_req   = up_req;
        dn_write = up_write;
        dn_lock  = 1'b0;
        dn_addr  = up_addr;
        dn_wdata = up_wdata;
        dn_strb  = up_strb;
        up_ready = dn_ready;
        up_rdata = dn_rdata;
        if (in_write) begin
            dn_req   = 1'b1;
            dn_write = 1'b1;
            dn_lock  = 1'b1;
            dn_addr  = hold_addr;
            dn_wdata = hold_word;
            dn_strb  = hold_strb;
            up_rdata = '0;
        end else if (up_req && alias_hit) begin
            dn_write = 1'b0;
            dn_addr  = tgt.byte_addr;
            dn_wdata = '0;
            dn_strb  = lane_strb;
            up_rdata = '0;
            if (up_write) begin
                dn_lock  = 1'b1;
                up_ready = 1'b0;
            end else begin
                up_rdata = {{(DATA_W-1){1'b0}}, rd_bit};
            end
        end
    end

endmodule

// File: rtl/bitband_xlate_checker.sv
// Protocol checker for the translator, bound to every instance of the top.
// Decodes the alias windows on its own from the window parameters.
module bitband_xlate_checker #(
    parameter int                        ADDR_W      = 32,
    parameter int                        DATA_W      = 32,
    parameter int                        NUM_WIN     = 2,
    parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN*8-1:0]      SPAN_LOG2S  = {8'd24, 8'd23},
    localparam int                       LANES       = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_req,
    input logic              up_write,
    input logic              up_core,
    input logic [ADDR_W-1:0] up_addr,
    input logic              up_ready,
    input logic [DATA_W-1:0] up_rdata,
    input logic              dn_req,
    input logic              dn_write,
    input logic              dn_lock,
    input logic [ADDR_W-1:0] dn_addr,
    input logic [LANES-1:0]  dn_strb,
    input logic              dn_ready
);
    logic in_win;

    // Independent range compare against each window
    always_comb begin
        in_win = 1'b0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (up_addr >= ALIAS_BASES[i*ADDR_W +: ADDR_W] &&
                up_addr <= ALIAS_BASES[i*ADDR_W +: ADDR_W] +
                           ((ADDR_W'(1) << SPAN_LOG2S[i*8 +: 8]) - ADDR_W'(1)))
                in_win = 1'b1;
        end
    end

    assert_read_one_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        up_req && !up_write && up_core && in_win && up_ready |-> up_rdata[DATA_W-1:1] == '0);

    assert_locked_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_ready && dn_lock && !dn_write |=> dn_req && dn_write && dn_lock);

    assert_locked_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_lock |-> $countones(dn_strb) == 1);

    assert_write_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        up_req && up_write && up_core && in_win && up_ready |-> dn_req && dn_write && dn_lock && dn_ready);

    assert_pass_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        up_req && !in_win |-> dn_req && dn_addr == up_addr && !dn_lock);

    assert_other_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
        up_req && !up_core |-> dn_addr == up_addr && !dn_lock);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !up_req |-> !dn_req && !dn_lock);

endmodule

bind bitband_xlate bitband_xlate_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .NUM_WIN     (NUM_WIN),
    .ALIAS_BASES (ALIAS_BASES),
    .SPAN_LOG2S  (SPAN_LOG2S)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_req   (up_req),
    .up_write (up_write),
    .up_core  (up_core),
    .up_addr  (up_addr),
    .up_ready (up_ready),
    .up_rdata (up_rdata),
    .dn_req   (dn_req),
    .dn_write (dn_write),
    .dn_lock  (dn_lock),
    .dn_addr  (dn_addr),
    .dn_strb  (dn_strb),
    .dn_ready (dn_ready)
);

// File: tb/bitband_xlate_tb_top.sv
// Directed bench: one task per scenario, a small word memory downstream with
// programmable wait states, and a monitor of downstream handshakes.
module bitband_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_req = 1'b0, up_write = 1'b0, up_core = 1'b1;
    logic [31:0] up_addr = '0, up_wdata = '0;
    logic [3:0]  up_strb = '0;
    logic        up_ready;
    logic [31:0] up_rdata;
    logic        dn_req, dn_write, dn_lock, dn_ready;
    logic [31:0] dn_addr, dn_wdata, dn_rdata;
    logic [3:0]  dn_strb;

    int errors = 0, checks = 0;
    int wait_cfg = 0, wcnt = 0;
    logic [31:0] mem [512];
    logic [31:0] mon_addr, mon_wdata;
    logic [3:0]  mon_strb;
    logic        mon_write, mon_lock;
    int          lock_rd_cnt = 0, lock_wr_cnt = 0, hs_cnt = 0;

    always #4 clk = ~clk;   // 125 MHz

    bitband_xlate dut_i (
        .clk(clk), .rst_n(rst_n),
        .up_req(up_req), .up_write(up_write), .up_core(up_core), .up_addr(up_addr),
        .up_wdata(up_wdata), .up_strb(up_strb), .up_ready(up_ready), .up_rdata(up_rdata),
        .dn_req(dn_req), .dn_write(dn_write), .dn_lock(dn_lock), .dn_addr(dn_addr),
        .dn_wdata(dn_wdata), .dn_strb(dn_strb), .dn_ready(dn_ready), .dn_rdata(dn_rdata)
    );

    function automatic int midx(input logic [31:0] a);
        return int'({a[30], a[9:2]});
    endfunction

    assign dn_ready = dn_req && (wcnt >= wait_cfg);
    assign dn_rdata = mem[midx(dn_addr)];

    // Downstream memory, wait counter and handshake monitor
    always @(posedge clk) begin
        if (!rst_n) wcnt <= 0;
        else if (dn_req && dn_ready) wcnt <= 0;
        else if (dn_req) wcnt <= wcnt + 1;
        if (rst_n && dn_req && dn_ready) begin
            if (dn_write)
                for (int b = 0; b < 4; b++)
                    if (dn_strb[b]) mem[midx(dn_addr)][8*b +: 8] <= dn_wdata[8*b +: 8];
            mon_addr  <= dn_addr;
            mon_wdata <= dn_wdata;
            mon_strb  <= dn_strb;
            mon_write <= dn_write;
            mon_lock  <= dn_lock;
            hs_cnt    <= hs_cnt + 1;
            if (dn_lock && !dn_write) lock_rd_cnt <= lock_rd_cnt + 1;
            if (dn_lock && dn_write)  lock_wr_cnt <= lock_wr_cnt + 1;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic core, input logic [31:0] a,
                          input logic [31:0] d, input logic [3:0] s,
                          output logic [31:0] rd, output int cyc);
        @(negedge clk);
        up_req = 1'b1; up_write = w; up_core = core; up_addr = a; up_wdata = d; up_strb = s;
        cyc = 0; rd = '0;
        for (int k = 0; k < 1000; k++) begin
            #2;
            cyc++;
            if (up_ready) begin
                rd = up_rdata;
                break;
            end
            @(negedge clk);
        end
        @(posedge clk);
        #1;
        up_req = 1'b0; up_write = 1'b0; up_core = 1'b1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!dn_req, "R9 dn_req idle", 32'(dn_req), 0);
        chk(!dn_lock, "R9 dn_lock idle", 32'(dn_lock), 0);
        chk(!up_ready, "R9 up_ready idle", 32'(up_ready), 0);
    endtask

    task automatic t_sram_read;
        logic [31:0] rd; int cyc; int h0;
        mem[midx(32'h2000_0300)] = 32'h0000_0004;
        h0 = hs_cnt;
        access(0, 1, 32'h2200_6008, 0, 4'hF, rd, cyc);
        chk(rd == 32'h1, "R3 alias read bit set", rd, 1);
        chk(mon_addr == 32'h2000_0300, "R1 target byte addr", mon_addr, 32'h2000_0300);
        chk(mon_strb == 4'b0001 && !mon_write, "R3 byte read lane0", 32'(mon_strb), 1);
        chk(hs_cnt == h0 + 1, "R3 single downstream read", 32'(hs_cnt - h0), 1);
        chk(!mon_lock, "R10 no lock on alias read", 32'(mon_lock), 0);
        mem[midx(32'h2000_0300)] = 32'hFFFF_FFFB;
        access(0, 1, 32'h2200_6008, 0, 4'hF, rd, cyc);
        chk(rd == 32'h0, "R3 alias read bit clear", rd, 0);
        mem[midx(32'h2000_0300)] = 32'h0020_0000;
        access(0, 1, 32'h2200_6054, 0, 4'hF, rd, cyc);
        chk(rd == 32'h1, "R3 lane2 bit5", rd, 1);
        chk(mon_strb == 4'b0100 && mon_addr == 32'h2000_0302, "R1 lane2 strobe", 32'(mon_strb), 4);
    endtask

    task automatic t_sram_write;
        logic [31:0] rd; int cyc; int lr, lw;
        mem[midx(32'h2000_0300)] = 32'h1234_5678;
        lr = lock_rd_cnt; lw = lock_wr_cnt;
        access(1, 1, 32'h2200_6020, 32'h1, 4'h0, rd, cyc);
        chk(mem[midx(32'h2000_0300)] == 32'h1234_5778, "R4 rmw set bit0 byte1",
            mem[midx(32'h2000_0300)], 32'h1234_5778);
        chk(mon_write && mon_lock && mon_strb == 4'b0010, "R4 byte write strobe", 32'(mon_strb), 2);
        chk(mon_wdata == 32'h5757_5757, "R4 replicated byte", mon_wdata, 32'h5757_5757);
        chk(lock_rd_cnt == lr + 1 && lock_wr_cnt == lw + 1, "R10 locked read+write",
            32'(lock_wr_cnt - lw), 1);
        chk(cyc == 2, "R6 alias write latency w=0", 32'(cyc), 2);
    endtask

    task automatic t_bit0_only;
        logic [31:0] rd; int cyc;
        access(1, 1, 32'h2200_6020, 32'hFFFF_FFFE, 4'hF, rd, cyc);
        chk(mem[midx(32'h2000_0300)] == 32'h1234_5678, "R5 only bit0 used (clear)",
            mem[midx(32'h2000_0300)], 32'h1234_5678);
        access(1, 1, 32'h2200_607C, 32'h0000_0001, 4'h1, rd, cyc);
        chk(mem[midx(32'h2000_0300)] == 32'h9234_5678, "R5 set bit7 byte3",
            mem[midx(32'h2000_0300)], 32'h9234_5678);
    endtask

    task automatic t_periph;
        logic [31:0] rd; int cyc;
        mem[midx(32'h4000_0010)] = 32'h0;
        access(1, 1, 32'h4200_027C, 32'h1, 4'hF, rd, cyc);
        chk(mem[midx(32'h4000_0010)] == 32'h8000_0000, "R2 periph rmw bit7 byte 0x13",
            mem[midx(32'h4000_0010)], 32'h8000_0000);
        access(0, 1, 32'h4200_027C, 0, 4'hF, rd, cyc);
        chk(rd == 32'h1, "R2 periph read back", rd, 1);
        access(0, 1, 32'h4200_0278, 0, 4'hF, rd, cyc);
        chk(rd == 32'h0, "R2 periph neighbour bit", rd, 0);
        mem[midx(32'h4007_FFFF)] = 32'h8000_0000;
        access(0, 1, 32'h42FF_FFFC, 0, 4'hF, rd, cyc);
        chk(mon_addr == 32'h4007_FFFF && mon_strb == 4'b1000, "R2 window top addr", mon_addr, 32'h4007_FFFF);
        chk(rd == 32'h1, "R2 window top bit7", rd, 1);
    endtask

    task automatic t_wait;
        logic [31:0] rd; int cyc;
        wait_cfg = 3;
        mem[midx(32'h2000_0300)] = 32'h0;
        access(1, 1, 32'h2200_6008, 32'h1, 4'hF, rd, cyc);
        chk(cyc == 8, "R6 alias write latency w=3", 32'(cyc), 8);
        chk(mem[midx(32'h2000_0300)] == 32'h4, "R6 rmw result with waits", mem[midx(32'h2000_0300)], 4);
        access(0, 1, 32'h2200_6008, 0, 4'hF, rd, cyc);
        chk(cyc == 4 && rd == 32'h1, "R6 alias read latency w=3", 32'(cyc), 4);
        wait_cfg = 0;
    endtask

    task automatic t_passthru;
        logic [31:0] rd; int cyc;
        mem[midx(32'h2000_0100)] = 32'h0;
        access(1, 1, 32'h2000_0100, 32'hCAFE_F00D, 4'b0011, rd, cyc);
        chk(mem[midx(32'h2000_0100)] == 32'h0000_F00D, "R7 plain write strobes",
            mem[midx(32'h2000_0100)], 32'h0000_F00D);
        chk(!mon_lock && mon_addr == 32'h2000_0100, "R7 plain no lock", mon_addr, 32'h2000_0100);
        mem[midx(32'h2280_0000)] = 32'hA5A5_5A5A;
        access(0, 1, 32'h2280_0000, 0, 4'hF, rd, cyc);
        chk(rd == 32'hA5A5_5A5A && mon_addr == 32'h2280_0000, "R7 just past sram window", rd, 32'hA5A5_5A5A);
        mem[midx(32'h41FF_FFFC)] = 32'h0BAD_CAFE;
        access(0, 1, 32'h41FF_FFFC, 0, 4'hF, rd, cyc);
        chk(rd == 32'h0BAD_CAFE && mon_addr == 32'h41FF_FFFC, "R7 just below periph window", rd, 32'h0BAD_CAFE);
    endtask

    task automatic t_other;
        logic [31:0] rd; int cyc; int lw;
        mem[midx(32'h2200_6008)] = 32'h1111_0000;
        access(0, 0, 32'h2200_6008, 0, 4'hF, rd, cyc);
        chk(rd == 32'h1111_0000 && mon_addr == 32'h2200_6008, "R8 other initiator read", rd, 32'h1111_0000);
        lw = lock_wr_cnt;
        access(1, 0, 32'h2200_6008, 32'h7777_7777, 4'hF, rd, cyc);
        chk(mon_write && !mon_lock && mon_addr == 32'h2200_6008 && cyc == 1,
            "R8 other initiator write untranslated", mon_addr, 32'h2200_6008);
        chk(lock_wr_cnt == lw, "R10 no lock for other initiator", 32'(lock_wr_cnt - lw), 0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_sram_read();
        t_sram_write();
        t_bit0_only();
        t_periph();
        t_wait();
        t_passthru();
        t_other();
        repeat (2) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule